// File: doc/BRIEF.md
# Execute-in-place boot image sequencer

This block runs once per boot attempt on a directly addressable external memory. After a start pulse it spends a fixed number of cycles on interface setup. It then reads the first 32-bit word at the device base (0x0800_0000) through a word-read master port. If that word equals a programmable header signature, the block copies the first 512-byte sector into an internal RAM, one 16-bit word at a time. It then picks the image location, compares the word found there with a second programmable signature, and reports the result.

On success the caller receives the entry address to jump to. On failure the caller receives a fail status and moves on to the next boot device. A read error during the sector copy also ends the attempt with a fail status; it does not fall through to the image check. The result outputs stay frozen until the next start pulse.

The states are IDLE, CFG, HDR_LO, HDR_HI, COPY_RD, COPY_WR, IMG_LO and IMG_HI. The transitions are:
- IDLE goes to CFG on start.
- CFG goes to HDR_LO when the setup timer expires.
- HDR_LO goes to HDR_HI on a good response, or to IMG_LO on an error.
- HDR_HI goes to COPY_RD on a signature match, or to IMG_LO on a mismatch or an error.
- COPY_RD goes to COPY_WR on a good response, or to IDLE with a failure on an error.
- COPY_WR goes back to COPY_RD, or to IMG_LO after the last word.
- IMG_LO goes to IMG_HI on a good response, or to IDLE with a failure on an error.
- IMG_HI goes to IDLE with a pass or a failure.

Top module: `xip_boot_seq`

## Requirements
- R1: While reset is held, and after reset until the first start, done, pass, entry_addr, mem_req and ram_we are all 0.
- R2: A start pulse accepted in IDLE is followed by exactly CFG_CYCLES cycles with no read request. The first read then targets 0x0800_0000 and the second targets 0x0800_0002. The 32-bit word is {second half, first half}.
- R3: The header counts as present only when the probe word equals hdr_sig. An error response on either probe read makes the header count as absent.
- R4: When the header is present, the block issues 256 reads at 0x0800_0000 + 2*i for i = 0 to 255, in order. Each read is followed by a one-cycle ram_we at ram_addr i carrying the returned data, with no read request in that cycle.
- R5: The image word is read at 0x0800_0000 and 0x0800_0002 when the header is absent, and at 0x0800_0200 and 0x0800_0202 when it is present.
- R6: When the image word equals img_sig, the block raises done with pass=1 and entry_addr equal to the image location.
- R7: When the image word differs from img_sig, or an image read returns an error, the block raises done with pass=0 and entry_addr=0.
- R8: An error response during the sector copy ends the attempt at once with done=1, pass=0 and entry_addr=0. No further reads or RAM writes follow.
- R9: The block clears done, pass and entry_addr in the cycle after an accepted start. Once done is set, all three hold their values until the next start.
- R10: A start pulse that arrives while a sequence is running is ignored. The read and write order and the final result do not change.
- R11: A read request holds mem_req high and mem_addr stable until mem_valid or mem_err answers it. At most one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a boot attempt |
| hdr_sig | input | 32 | Signature that marks a configuration header |
| img_sig | input | 32 | Signature that marks a bootable image |
| mem_req | output | 1 | Read request to external memory |
| mem_addr | output | 32 | Byte address of the requested 16-bit word |
| mem_rdata | input | 16 | Read data, qualified by mem_valid |
| mem_valid | input | 1 | Successful read response |
| mem_err | input | 1 | Error read response |
| ram_we | output | 1 | Internal RAM write strobe |
| ram_addr | output | 8 | Internal RAM word address |
| ram_wdata | output | 16 | Internal RAM write data |
| done | output | 1 | Attempt finished |
| pass | output | 1 | Attempt found a bootable image |
| entry_addr | output | 32 | Image entry address on pass, otherwise 0 |

## Verification
The sequence is run with several memory images:
- No header and a good image, which confirms the image check at the base address.
- A header and a good image, which confirms the full copy and the move of the image by one sector.
- A header and a bad image, and no header and no image, which separate the pass and fail result paths.
- An error in the middle of the copy, which shows that the copy error aborts instead of falling through to the image check.
- An error on the probe read while the header and image signatures are equal, which shows that a probe error counts as "no header" and not as failure.
- An error on an image read, which must give a fail result.

Response latency is varied between runs, and one run pulses start in the middle of the copy to show that a busy sequence ignores it.

// File: rtl/xip_boot_pkg.sv
package xip_boot_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CFG,
        ST_HDR_LO,
        ST_HDR_HI,
        ST_COPY_RD,
        ST_COPY_WR,
        ST_IMG_LO,
        ST_IMG_HI
    } boot_state_t;
endpackage

// File: rtl/xip_cfg_timer.sv
module xip_cfg_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    generate
        if (CYCLES <= 1) begin : g_single
            assign expired = run;
        end else begin : g_count
            localparam int CNT_W = $clog2(CYCLES);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run || expired) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign expired = run && (cnt_q == CNT_W'(CYCLES - 1));
        end
    endgenerate
endmodule

// File: rtl/xip_sig_match.sv
module xip_sig_match #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_lo,
    input  logic [HALF_W-1:0] half_in,
    input  logic [2*HALF_W-1:0] sig,
    output logic              match
);
    logic [HALF_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (cap_lo) begin
            lo_q <= half_in;
        end
    end

    assign match = ({half_in, lo_q} == sig);
endmodule

// File: rtl/xip_sector_ctr.sv
module xip_sector_ctr #(
    parameter int WORDS = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       inc,
    output logic [$clog2(WORDS)-1:0]   idx,
    output logic                       last
);
    localparam int IDX_W = $clog2(WORDS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (inc) begin
            idx <= idx + 1'b1;
        end
    end

    assign last = (idx == IDX_W'(WORDS - 1));
endmodule

// File: rtl/xip_boot_seq.sv
module xip_boot_seq
    import xip_boot_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter int          DATA_W       = 16,
    parameter int          SECTOR_BYTES = 512,
    parameter int          CFG_CYCLES   = 4,
    parameter logic [31:0] BASE_ADDR    = 32'h0800_0000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic [2*DATA_W-1:0]                   hdr_sig,
    input  logic [2*DATA_W-1:0]                   img_sig,
    output logic                                  mem_req,
    output logic [ADDR_W-1:0]                     mem_addr,
    input  logic [DATA_W-1:0]                     mem_rdata,
    input  logic                                  mem_valid,
    input  logic                                  mem_err,
    output logic                                  ram_we,
    output logic [$clog2(SECTOR_BYTES/(DATA_W/8))-1:0] ram_addr,
    output logic [DATA_W-1:0]                     ram_wdata,
    output logic                                  done,
    output logic                                  pass,
    output logic [ADDR_W-1:0]                     entry_addr
);
    localparam int STEP   = DATA_W / 8;
    localparam int WORDS  = SECTOR_BYTES / STEP;
    localparam int IDX_W  = $clog2(WORDS);
    localparam logic [ADDR_W-1:0] BASE    = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] STEP_A  = ADDR_W'(STEP);
    localparam logic [ADDR_W-1:0] SECT_A  = ADDR_W'(SECTOR_BYTES);

    boot_state_t state_q, state_d;

    logic              cfg_expired;
    logic              sig_match;
    logic              sig_cap;
    logic [2*DATA_W-1:0] sig_sel;
    logic [IDX_W-1:0]  copy_idx;
    logic              copy_last;
    logic              hdr_found_q;
    logic [DATA_W-1:0] data_q;
    logic              rsp_ok;
    logic              rsp_err;
    logic [ADDR_W-1:0] img_base;
    logic              finish_fail;
    logic              finish_pass;

    assign rsp_err  = mem_req && mem_err;
    assign rsp_ok   = mem_req && mem_valid && !mem_err;
    assign img_base = hdr_found_q ? (BASE + SECT_A) : BASE;

    xip_cfg_timer #(.CYCLES(CFG_CYCLES)) u_cfg_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_CFG),
        .expired (cfg_expired)
    );

    assign sig_cap = rsp_ok && ((state_q == ST_HDR_LO) || (state_q == ST_IMG_LO));
    assign sig_sel = (state_q == ST_HDR_HI) ? hdr_sig : img_sig;

    xip_sig_match #(.HALF_W(DATA_W)) u_sig_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_lo  (sig_cap),
        .half_in (mem_rdata),
        .sig     (sig_sel),
        .match   (sig_match)
    );

    xip_sector_ctr #(.WORDS(WORDS)) u_sector_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_IDLE),
        .inc   (state_q == ST_COPY_WR),
        .idx   (copy_idx),
        .last  (copy_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CFG;
            ST_CFG:     if (cfg_expired) state_d = ST_HDR_LO;
            ST_HDR_LO: begin
                if (rsp_err)     state_d = ST_IMG_LO;
                else if (rsp_ok) state_d = ST_HDR_HI;
            end
            ST_HDR_HI: begin
                if (rsp_err)     state_d = ST_IMG_LO;
                else if (rsp_ok) state_d = sig_match ? ST_COPY_RD : ST_IMG_LO;
            end
            ST_COPY_RD: begin
                if (rsp_err)     state_d = ST_IDLE;
                else if (rsp_ok) state_d = ST_COPY_WR;
            end
            ST_COPY_WR: state_d = copy_last ? ST_IMG_LO : ST_COPY_RD;
            ST_IMG_LO: begin
                if (rsp_err)     state_d = ST_IDLE;
                else if (rsp_ok) state_d = ST_IMG_HI;
            end
            ST_IMG_HI: begin
                if (rsp_err || rsp_ok) state_d = ST_IDLE;
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Port-side strobes and addresses
    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = '0;
        ram_we    = 1'b0;
        ram_addr  = copy_idx;
        ram_wdata = data_q;
        unique case (state_q)
            ST_HDR_LO:  begin mem_req = 1'b1; mem_addr = BASE; end
            ST_HDR_HI:  begin mem_req = 1'b1; mem_addr = BASE + STEP_A; end
            ST_COPY_RD: begin
                mem_req  = 1'b1;
                mem_addr = BASE + ADDR_W'(copy_idx) * STEP_A;
            end
            ST_COPY_WR: ram_we = 1'b1;
            ST_IMG_LO:  begin mem_req = 1'b1; mem_addr = img_base; end
            ST_IMG_HI:  begin mem_req = 1'b1; mem_addr = img_base + STEP_A; end
            default:    ;
        endcase
    end

    assign finish_fail = ((state_q == ST_COPY_RD) && rsp_err)
                      || ((state_q == ST_IMG_LO) && rsp_err)
                      || ((state_q == ST_IMG_HI) && (rsp_err || (rsp_ok && !sig_match)));
    assign finish_pass = (state_q == ST_IMG_HI) && rsp_ok && sig_match;

    // Sequence bookkeeping and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_found_q <= 1'b0;
            data_q      <= '0;
            done        <= 1'b0;
            pass        <= 1'b0;
            entry_addr  <= '0;
        end else begin
            if ((state_q == ST_IDLE) && start) begin
                hdr_found_q <= 1'b0;
                done        <= 1'b0;
                pass        <= 1'b0;
                entry_addr  <= '0;
            end
            if ((state_q == ST_HDR_HI) && rsp_ok && sig_match) begin
                hdr_found_q <= 1'b1;
            end
            if ((state_q == ST_COPY_RD) && rsp_ok) begin
                data_q <= mem_rdata;
            end
            if (finish_fail) begin
                done       <= 1'b1;
                pass       <= 1'b0;
                entry_addr <= '0;
            end
            if (finish_pass) begin
                done       <= 1'b1;
                pass       <= 1'b1;
                entry_addr <= img_base;
            end
        end
    end
endmodule

// File: rtl/xip_boot_seq_chk.sv
module xip_boot_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_valid,
    input logic        mem_err,
    input logic        ram_we,
    input logic        done,
    input logic        pass,
    input logic [31:0] entry_addr
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid && !mem_err) |=> (mem_req && $stable(mem_addr)));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(entry_addr)));

    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

    // R7
    fail_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> (entry_addr == 32'h0));

    // R4
    wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !mem_req);

    // R6
    pass_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);
endmodule

bind xip_boot_seq xip_boot_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .mem_err    (mem_err),
    .ram_we     (ram_we),
    .done       (done),
    .pass       (pass),
    .entry_addr (entry_addr)
);

// File: tb/xip_boot_seq_tb_top.sv
module xip_boot_seq_tb_top;
    localparam int          CFG = 4;
    localparam logic [31:0] BASE = 32'h0800_0000;
    localparam logic [31:0] HSIG = 32'hC0DE_5A5A;
    localparam logic [31:0] ISIG = 32'hB007_1A6E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] hdr_sig = HSIG;
    logic [31:0] img_sig = ISIG;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        mem_valid = 1'b0;
    logic        mem_err = 1'b0;
    logic        ram_we;
    logic [7:0]  ram_addr;
    logic [15:0] ram_wdata;
    logic        done;
    logic        pass;
    logic [31:0] entry_addr;

    always #5 clk = ~clk;

    xip_boot_seq #(.CFG_CYCLES(CFG)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .hdr_sig(hdr_sig), .img_sig(img_sig),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_valid(mem_valid), .mem_err(mem_err),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .done(done), .pass(pass), .entry_addr(entry_addr)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [15:0] mem [0:1023];
    logic [31:0] exp_rd[$];
    logic [23:0] exp_wr[$];
    int lat = 0;
    int err_at = -1;
    int rd_cnt = 0;
    int wait_cnt = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wd(input int k);
        return {mem[k+1], mem[k]};
    endfunction

    // Memory responder and read-order model (R2 R4 R5 R11)
    always @(negedge clk) begin
        if (mem_valid || mem_err) begin
            mem_valid = 1'b0;
            mem_err   = 1'b0;
            wait_cnt  = 0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                if (exp_rd.size() == 0) begin
                    check(1'b0, "R8 unexpected read", mem_addr, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_rd.pop_front();
                    check(mem_addr == e, "R2/R4/R5 read address", mem_addr, e);
                end
                if (rd_cnt == err_at) begin
                    mem_err = 1'b1;
                end else begin
                    int ix;
                    ix = int'((mem_addr - BASE) >> 1);
                    mem_rdata = (ix >= 0 && ix < 1024) ? mem[ix] : 16'hDEAD;
                    mem_valid = 1'b1;
                end
                rd_cnt++;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    // RAM write monitor (R4)
    always @(negedge clk) begin
        if (ram_we) begin
            if (exp_wr.size() == 0) begin
                check(1'b0, "R8 unexpected RAM write", {24'h0, ram_addr}, 32'h0);
            end else begin
                logic [23:0] e;
                e = exp_wr.pop_front();
                check({ram_addr, ram_wdata} == e, "R4 RAM write", {8'h0, ram_addr, ram_wdata}, {8'h0, e});
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic fill(input int seed);
        for (int i = 0; i < 1024; i++) mem[i] = 16'((i * 16'h3b1) ^ seed);
    endtask

    task automatic put_word(input int k, input logic [31:0] w);
        mem[k]   = w[15:0];
        mem[k+1] = w[31:16];
    endtask

    // Builds the expected read and write order and the result from the requirements
    task automatic build(output bit exp_pass, output logic [31:0] exp_entry);
        int r;
        bit hdr, abort, e;
        logic [31:0] ib;
        exp_rd.delete();
        exp_wr.delete();
        r = 0; hdr = 0; abort = 0; exp_pass = 0; exp_entry = 32'h0;
        exp_rd.push_back(BASE);
        e = (r == err_at); r++;
        if (!e) begin
            exp_rd.push_back(BASE + 2);
            e = (r == err_at); r++;
            if (!e) hdr = (wd(0) == hdr_sig);
        end
        if (hdr) begin
            for (int i = 0; i < 256; i++) begin
                exp_rd.push_back(BASE + 32'(2 * i));
                e = (r == err_at); r++;
                if (e) begin abort = 1; break; end
                exp_wr.push_back({8'(i), mem[i]});
            end
        end
        if (!abort) begin
            ib = hdr ? BASE + 32'h200 : BASE;
            exp_rd.push_back(ib);
            e = (r == err_at); r++;
            if (!e) begin
                exp_rd.push_back(ib + 2);
                e = (r == err_at); r++;
                if (!e && wd(int'((ib - BASE) >> 1)) == img_sig) begin
                    exp_pass = 1;
                    exp_entry = ib;
                end
            end
        end
    endtask

    task automatic run(input string name, input int l, input int ea, input bit poke);
        bit ep;
        logic [31:0] ee;
        int quiet, n;
        bit poked;
        lat = l; err_at = ea; rd_cnt = 0;
        build(ep, ee);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: cleared after accepted start
        check(done == 1'b0 && pass == 1'b0 && entry_addr == 32'h0, "R9 cleared on start", {31'h0, done}, 32'h0);
        quiet = 0;
        while (!mem_req && quiet < 50) begin
            quiet++;
            @(negedge clk);
        end
        check(quiet == CFG, "R2 setup cycles", quiet, CFG);
        n = 0; poked = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            if (poke && !poked && rd_cnt == 50) begin
                start = 1'b1;
                poked = 1;
            end else begin
                start = 1'b0;
            end
            n++;
        end
        start = 1'b0;
        check(done, {name, " R6/R7 done"}, {31'h0, done}, 32'h1);
        check(pass == ep, {name, " R6/R7 pass"}, {31'h0, pass}, {31'h0, ep});
        check(entry_addr == ee, {name, " R6/R7 entry"}, entry_addr, ee);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(done && pass == ep && entry_addr == ee, {name, " R9 held"}, entry_addr, ee);
        end
        check(exp_rd.size() == 0, {name, " R8/R10 all reads seen"}, exp_rd.size(), 0);
        check(exp_wr.size() == 0, {name, " R8/R10 all writes seen"}, exp_wr.size(), 0);
    endtask

    initial begin
        fill(0);
        repeat (3) @(negedge clk);
        // R1 during reset
        check(!done && !pass && entry_addr == 0 && !mem_req && !ram_we, "R1 in reset", {31'h0, done}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done && !pass && entry_addr == 0 && !mem_req && !ram_we, "R1 after reset", entry_addr, 32'h0);

        // R5 R6: no header, image at base
        fill(11); put_word(0, ISIG);
        run("s1", 1, -1, 0);
        // R3 R4 R5 R6 R10: header, copy, image one sector on; start during copy
        fill(22); put_word(0, HSIG); put_word(256, ISIG);
        run("s2", 0, -1, 1);
        // R7: header but bad image
        fill(33); put_word(0, HSIG); put_word(256, 32'h1234_5678);
        run("s3", 2, -1, 0);
        // R7: neither header nor image
        fill(44); put_word(0, 32'h0BAD_0BAD);
        run("s4", 1, -1, 0);
        // R8: error in the middle of the copy
        fill(55); put_word(0, HSIG); put_word(256, ISIG);
        run("s5", 0, 102, 0);
        // R3: probe error means no header, image still checked at base
        fill(66); hdr_sig = ISIG; put_word(0, ISIG);
        run("s6", 1, 0, 0);
        hdr_sig = HSIG;
        // R7: error on image read
        fill(77); put_word(0, ISIG);
        run("s7", 0, 3, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule